// File: doc/BRIEF.md
# Folded Two-Multiplier FIR Filter

This block is a nine-tap (eighth-order) finite impulse response filter for signed fixed-point samples. It has a ready/valid stream on each side. It does not spend one multiplier per tap. Instead, two shared multipliers work through the taps two at a time, and a small state machine steps them across the tap delay line. Each output sample therefore costs several clock cycles, and the upstream source must wait between samples. The input ready signal enforces that wait.

The nine coefficients arrive on a parallel port and are sampled every cycle. Change them only while the filter is idle. When a sample is accepted, it enters the delay line and the old contents move one place along. Both samples and coefficients are widened to an internal format: the integer part is sign-extended and the extra fractional bits are filled with zeros. The filter then sums the pair products into an accumulator. It rescales the total by an arithmetic right shift, truncates it to the output width, and holds the result until the downstream side takes it.

The sequencer has five states:

- IDLE: the filter is ready for a sample. Acceptance moves it to ARM.
- ARM: a single wait cycle. The filter always moves on to MAC.
- MAC: one tap pair is processed per cycle. After the final step the filter moves to FINISH.
- FINISH: the output is registered and the accumulator is cleared. The filter always moves on to HOLD.
- HOLD: the output is valid. When the downstream handshake completes, the filter returns to IDLE.

Top module: `fir9_fold2`

## Requirements
- R1: After a synchronous active-low reset, `s_tready` is 1, `m_tvalid` is 0, and every tap holds zero. The first result after reset therefore depends only on the samples accepted since then.
- R2: With default formats (16-bit words, 15 fractional bits), each result is computed as y = Σ_{k=0..8} c_k·x[n−k], using the signed coefficient c_k from `coef_taps[k]` (bits 16k+15..16k). The sum is arithmetic-shifted right by 15 and its low 16 bits form the result.
- R3: The delay line shifts only on an accepted sample (`s_tvalid` and `s_tready` both 1). Data offered while `s_tready` is 0 never enters any result.
- R4: A result becomes valid exactly 7 clock edges after the edge that accepted its sample. Those 7 edges are one ARM cycle, five MAC steps and one FINISH cycle.
- R5: `s_tready` falls on the edge after an acceptance and stays 0 until the edge at which `m_tvalid` and `m_tready` are both 1. It is 1 again in the following cycle.
- R6: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata` and `m_tlast` hold their values.
- R7: `m_tlast` equals the `s_tlast` value that was accepted with the sample the result was computed from.
- R8: The accumulator is zeroed when a result is registered, so each result depends on no earlier sum.
- R9: A reset asserted in the middle of a computation abandons it. No result appears, `s_tready` returns to 1, and the tap history is cleared.
- R10: Overflow of the 16-bit result wraps. For example, with every coefficient and every tap at −32768, the output is 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | DW | Input sample, signed |
| s_tlast | input | 1 | Packet-end flag of the input sample |
| s_tvalid | input | 1 | Input sample valid |
| s_tready | output | 1 | Filter can take a sample |
| m_tdata | output | DW | Filtered sample, signed |
| m_tlast | output | 1 | Packet-end flag of the result |
| m_tvalid | output | 1 | Result valid |
| m_tready | input | 1 | Downstream takes the result |
| coef_taps | input | NTAP×CW | Coefficient k in element k, signed |

## Verification
Two events can fall in the same cycle: the output handshake that ends a computation, and a new sample offered at the input. The bench keeps `s_tvalid` high with junk data throughout the busy period. It also holds back `m_tready` in a pattern, so that the release of the output coincides with an input offer. A cycle-accurate reference then checks three things against the design on every clock: that the junk data was not taken, that `s_tready` rises exactly one cycle after the release, and that the next result reflects only the samples that were truly accepted. The accumulator clear and the output register load also happen on the same edge. Back-to-back results compared against independently computed sums show whether the clear took effect.

// File: rtl/fir_fold_pkg.sv
package fir_fold_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_MAC,
        ST_FINISH,
        ST_HOLD
    } seq_state_t;

    // number of sequencer steps needed to cover ntap taps two at a time
    function automatic int pair_steps(input int ntap);
        return (ntap + 1) / 2;
    endfunction

endpackage

// File: rtl/fir_tapline.sv
module fir_tapline #(
    parameter int NTAP = 9,
    parameter int DW   = 16,
    parameter int DF   = 15,
    parameter int IW   = 16,
    parameter int IF   = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic [DW-1:0]            din,
    output logic [NTAP-1:0][IW-1:0]  taps
);
    localparam int FRAC_PAD = IF - DF;

    logic signed [IW-1:0] din_wide;

    // widen: sign extend the integer side, zero fill the fraction side
    always_comb begin
        din_wide = IW'($signed(din));
        din_wide = din_wide <<< FRAC_PAD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps <= '0;
        end else if (shift_en) begin
            taps[0] <= din_wide;
            for (int i = 1; i < NTAP; i++) begin
                taps[i] <= taps[i-1];
            end
        end
    end

    assert_taps_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(taps));

endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
    parameter int NTAP = 9,
    parameter int CW   = 16,
    parameter int CF   = 15,
    parameter int IW   = 16,
    parameter int IF   = 15,
    parameter int SW   = 3,
    parameter int AW   = 36
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NTAP-1:0][IW-1:0]  taps,
    input  logic [NTAP-1:0][CW-1:0]  coefs,
    input  logic [SW-1:0]            step,
    input  logic                     mac_en,
    input  logic                     clear,
    output logic signed [AW-1:0]     acc
);
    localparam int PW       = 2 * IW;
    localparam int FRAC_PAD = IF - CF;
    localparam int LANES    = 2;

    logic signed [IW-1:0] coef_wide [NTAP];
    logic signed [IW-1:0] opx       [LANES];
    logic signed [IW-1:0] opc       [LANES];
    logic signed [PW-1:0] prod      [LANES];
    logic        [SW:0]   idx       [LANES];

    for (genvar k = 0; k < NTAP; k++) begin : g_coef
        assign coef_wide[k] = $signed(IW'($signed(coefs[k]))) <<< FRAC_PAD;
    end

    // lane 0 takes the even tap of the current pair, lane 1 the odd tap
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign idx[l] = {step, 1'(l)};

        always_comb begin
            opx[l] = '0;
            opc[l] = '0;
            for (int i = 0; i < NTAP; i++) begin
                if (idx[l] == (SW+1)'(i)) begin
                    opx[l] = $signed(taps[i]);
                    opc[l] = coef_wide[i];
                end
            end
        end

        assign prod[l] = PW'(opx[l]) * PW'(opc[l]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clear) begin
            acc <= '0;
        end else if (mac_en) begin
            acc <= acc + AW'(prod[0]) + AW'(prod[1]);
        end
    end

    assert_acc_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0));

    assert_acc_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mac_en && !clear) |=> $stable(acc));

endmodule

// File: rtl/fir_seq.sv
module fir_seq
    import fir_fold_pkg::*;
#(
    parameter int NSTEP = 5,
    parameter int SW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    input  logic          m_ready,
    output logic          s_ready,
    output logic          shift_en,
    output logic          mac_en,
    output logic [SW-1:0] step,
    output logic          emit,
    output logic          m_valid
);
    localparam logic [SW-1:0] LAST_STEP = SW'(NSTEP - 1);
    localparam int            LATENCY   = NSTEP + 2;

    seq_state_t state, state_nx;

    // state register and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            state <= state_nx;
            step  <= (state == ST_MAC) ? step + 1'b1 : '0;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (s_valid) state_nx = ST_ARM;
            ST_ARM:    state_nx = ST_MAC;
            ST_MAC:    if (step == LAST_STEP) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_HOLD;
            ST_HOLD:   if (m_ready) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        s_ready  = 1'b0;
        mac_en   = 1'b0;
        emit     = 1'b0;
        m_valid  = 1'b0;
        unique case (state)
            ST_IDLE:   s_ready = 1'b1;
            ST_ARM:    ;
            ST_MAC:    mac_en  = 1'b1;
            ST_FINISH: emit    = 1'b1;
            ST_HOLD:   m_valid = 1'b1;
            default:   ;
        endcase
        shift_en = s_ready && s_valid;
    end

    // cycles since the last acceptance, for the latency check only
    logic [7:0] since_accept;
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_accept <= '0;
        else if (shift_en)
            since_accept <= 8'd1;
        else if (since_accept != 0 && !m_valid && since_accept != 8'hFF)
            since_accept <= since_accept + 8'd1;
    end

    assert_ready_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> !s_ready);

    assert_ready_returns_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready) |=> (s_ready && !m_valid));

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> (since_accept == 8'(LATENCY + 1)));

endmodule

// File: rtl/fir9_fold2.sv
module fir9_fold2 #(
    parameter int NTAP = 9,
    parameter int DW   = 16,
    parameter int DF   = 15,
    parameter int CW   = 16,
    parameter int CF   = 15,
    parameter int IW   = 16,
    parameter int IF   = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DW-1:0]            s_tdata,
    input  logic                     s_tlast,
    input  logic                     s_tvalid,
    output logic                     s_tready,
    output logic [DW-1:0]            m_tdata,
    output logic                     m_tlast,
    output logic                     m_tvalid,
    input  logic                     m_tready,
    input  logic [NTAP-1:0][CW-1:0]  coef_taps
);
    localparam int NSTEP = fir_fold_pkg::pair_steps(NTAP);
    localparam int SW    = (NSTEP > 1) ? $clog2(NSTEP) : 1;
    localparam int AW    = 2 * IW + $clog2(NTAP);
    localparam int OSH   = 2 * IF - DF;

    logic                     shift_en;
    logic                     mac_en;
    logic                     emit;
    logic [SW-1:0]            step;
    logic [NTAP-1:0][IW-1:0]  taps;
    logic signed [AW-1:0]     acc;
    logic                     last_hold;
    logic [DW-1:0]            out_data;
    logic                     out_last;

    fir_seq #(.NSTEP(NSTEP), .SW(SW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_valid  (s_tvalid),
        .m_ready  (m_tready),
        .s_ready  (s_tready),
        .shift_en (shift_en),
        .mac_en   (mac_en),
        .step     (step),
        .emit     (emit),
        .m_valid  (m_tvalid)
    );

    fir_tapline #(.NTAP(NTAP), .DW(DW), .DF(DF), .IW(IW), .IF(IF)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (s_tdata),
        .taps     (taps)
    );

    fir_mac #(.NTAP(NTAP), .CW(CW), .CF(CF), .IW(IW), .IF(IF), .SW(SW), .AW(AW)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .taps   (taps),
        .coefs  (coef_taps),
        .step   (step),
        .mac_en (mac_en),
        .clear  (emit),
        .acc    (acc)
    );

    // output register: rescale, truncate, pair with the stored packet flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_hold <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else begin
            if (shift_en)
                last_hold <= s_tlast;
            if (emit) begin
                out_data <= DW'(acc >>> OSH);
                out_last <= last_hold;
            end
        end
    end

    assign m_tdata = out_data;
    assign m_tlast = out_last;

    assert_out_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    assert_flag_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !s_tready |=> $stable(last_hold));

endmodule

// File: tb/fir9_fold2_test.sv
module fir9_fold2_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       s_tdata = '0;
    logic              s_tlast = 1'b0;
    logic              s_tvalid = 1'b0;
    logic              s_tready;
    logic [15:0]       m_tdata;
    logic              m_tlast;
    logic              m_tvalid;
    logic              m_tready = 1'b1;
    logic [8:0][15:0]  coefs = '0;

    always #4 clk = ~clk;

    fir9_fold2 uut (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .coef_taps(coefs)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R2";

    // behavioural reference
    int          hist [9];
    bit          mbusy = 0;
    int          mcnt = 0;
    bit          mval = 0;
    logic [15:0] mdata = '0, pend_data = '0;
    bit          mlast = 0, pend_last = 0;
    bit          took_in = 0, took_out = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] ref_out();
        longint s = 0;
        for (int k = 0; k < 9; k++)
            s += longint'($signed(coefs[k])) * longint'(hist[k]);
        s = s >>> 15;
        return s[15:0];
    endfunction

    task automatic compare();
        chk(s_tready == !mbusy, "R5 ready", int'(s_tready), int'(!mbusy));
        chk(m_tvalid == mval, "R4 valid", int'(m_tvalid), int'(mval));
        if (mval) begin
            chk(m_tdata == mdata, {cur_tag, " data"}, int'(m_tdata), int'(mdata));
            chk(m_tlast == mlast, "R7 last", int'(m_tlast), int'(mlast));
        end
    endtask

    task automatic model_update(input bit rst, input bit sv, input logic [15:0] sd,
                                input bit sl, input bit mr);
        took_in = 0;
        took_out = 0;
        if (!rst) begin
            for (int k = 0; k < 9; k++) hist[k] = 0;
            mbusy = 0; mcnt = 0; mval = 0;
        end else if (sv && !mbusy) begin
            for (int k = 8; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = int'($signed(sd));
            pend_data = ref_out();
            pend_last = sl;
            mbusy = 1; mcnt = 7; took_in = 1;
        end else if (mcnt > 0) begin
            mcnt--;
            if (mcnt == 0) begin
                mval = 1; mdata = pend_data; mlast = pend_last;
            end
        end else if (mval && mr) begin
            mval = 0; mbusy = 0; took_out = 1;
        end
    endtask

    task automatic step(input bit rst, input bit sv, input logic [15:0] sd,
                        input bit sl, input bit mr);
        @(negedge clk);
        compare();
        rst_n = rst; s_tvalid = sv; s_tdata = sd; s_tlast = sl; m_tready = mr;
        model_update(rst, sv, sd, sl, mr);
    endtask

    // offer one sample, then wait for its result; optional junk offers and backpressure
    task automatic feed(input logic [15:0] x, input bit l, input bit bp, input bit noise);
        int k = 0;
        do begin
            step(1, 1, x, l, 1'b1);
        end while (!took_in);
        do begin
            step(1, noise, 16'($urandom), 1'($urandom), bp ? (k % 3 == 2) : 1'b1);
            k++;
        end while (!took_out);
    endtask

    initial begin
        for (int k = 0; k < 9; k++) hist[k] = 0;
        repeat (3) step(0, 0, '0, 0, 1);
        step(1, 0, '0, 0, 1);
        // R1: reset state at the ports
        chk(s_tready == 1'b1, "R1 ready after reset", int'(s_tready), 1);
        chk(m_tvalid == 1'b0, "R1 valid after reset", int'(m_tvalid), 0);

        for (int k = 0; k < 9; k++) coefs[k] = 16'(k * 1500 - 5000);

        // R1/R2: impulse walks through the coefficients, history starts at zero
        cur_tag = "R1";
        feed(16'h4000, 0, 0, 0);
        cur_tag = "R2";
        for (int k = 0; k < 10; k++) feed(16'h0000, 0, 0, 0);

        // R2/R8: random samples back to back
        cur_tag = "R8";
        for (int k = 0; k < 30; k++) feed(16'($urandom), 1'($urandom), 0, 0);

        // R3/R5/R6: junk offered while busy, output held back
        cur_tag = "R3";
        for (int k = 0; k < 25; k++) feed(16'($urandom), 1'($urandom), 1, 1);

        // R7: alternating packet flags
        cur_tag = "R7";
        for (int k = 0; k < 6; k++) feed(16'(k * 777), k[0], 0, 1);

        // R10: full-scale negative everywhere wraps to 0x8000
        cur_tag = "R10";
        for (int k = 0; k < 9; k++) coefs[k] = 16'h8000;
        for (int k = 0; k < 9; k++) feed(16'h8000, 0, 0, 0);
        chk(mdata == 16'h8000, "R10 reference wrap", int'(mdata), 32768);

        // R9: reset in the middle of a computation
        cur_tag = "R9";
        for (int k = 0; k < 9; k++) coefs[k] = 16'(300 * k + 100);
        do step(1, 1, 16'h1234, 1, 1); while (!took_in);
        repeat (3) step(1, 0, '0, 0, 1);
        step(0, 0, '0, 0, 1);
        step(0, 0, '0, 0, 1);
        step(1, 0, '0, 0, 1);
        chk(s_tready == 1'b1, "R9 ready after abort", int'(s_tready), 1);
        chk(m_tvalid == 1'b0, "R9 no result after abort", int'(m_tvalid), 0);
        repeat (12) step(1, 0, '0, 0, 1);
        chk(m_tvalid == 1'b0, "R9 still no result", int'(m_tvalid), 0);
        feed(16'h2000, 0, 0, 0);
        feed(16'h0000, 0, 0, 0);

        step(1, 0, '0, 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule